// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two timer/counter channels for a small 8-bit microcontroller. Each channel has a low count byte and a high count byte. One shared mode byte sets, for each channel, external gating, the count source (internal machine-cycle tick or an external event pin) and one of four counting arrangements. The four arrangements are a prescaled 13-bit count, a full 16-bit cascade, an 8-bit count with auto-reload, and a split arrangement. In the split arrangement channel 0 becomes two independent 8-bit counters, and channel 0's high byte takes over channel 1's run bit and channel 1's overflow flag.

Software reaches the mode byte, the four count bytes and the two overflow flags through a simple write/read register port. The run bits and the machine-cycle tick come from the surrounding core. Each flag is also a direct output, so an interrupt controller can use it, and an acknowledge input clears it.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset every count byte, the mode byte and both overflow flags read as zero.
- R2: Register addresses are 0 mode, 1 channel-0 low, 2 channel-0 high, 3 channel-1 low, 4 channel-1 high, 5 flags (bit 0 channel 0, bit 1 channel 1). Other addresses read zero. The mode byte holds channel 1's control in bits 7..4 and channel 0's in bits 3..0. Each nibble is gate (bit 3), source select (bit 2), mode (bits 1..0).
- R3: A channel advances only when its run bit is 1 and either its gate bit is 0 or its synchronized gate pin is high.
- R4: Source select 0 counts one step per machine-cycle tick. Source select 1 counts one step per falling edge of the count pin after a two-flop synchronizer, applied on a tick. At most one step is taken per tick, however many edges came before it.
- R5: Mode 00 counts in the low 5 bits of the low byte. A carry out of those bits increments the high byte. The upper 3 bits of the low byte keep their last written value.
- R6: Mode 01 counts high and low bytes as one 16-bit value.
- R7: Mode 10 increments the low byte. When the low byte passes 0xFF it is loaded from the high byte, and the high byte stays unchanged.
- R8: When channel 0 is in mode 11, its low byte is an 8-bit counter under channel 0's own controls and flag. Its high byte counts ticks while channel 1's run bit is 1 and sets channel 1's flag when it rolls over. Channel 1's own rollovers then leave that flag untouched.
- R9: Channel 1 in mode 11 holds both of its bytes.
- R10: A rollover of the active count from all ones to zero sets that channel's flag. A set in the same cycle as a clear leaves the flag set.
- R11: Writing 0 to a flag bit at address 5 clears that flag, and writing 1 has no effect. A high acknowledge input also clears its channel's flag.
- R12: A bus write to a count byte replaces that byte's increment in the same cycle. Changing a run bit never clears the count, so counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Machine-cycle tick |
| run_i | input | 2 | Run bit per channel |
| cnt_pin_i | input | 2 | External count pin per channel (asynchronous) |
| gate_pin_i | input | 2 | External gate pin per channel (asynchronous) |
| ack_i | input | 2 | Flag acknowledge per channel |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| ovf_o | output | 2 | Overflow flags, bit 0 channel 0, bit 1 channel 1 |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes, a 5-bit prescaler and two synchronizer stages. With these values every rollover is reachable in a handful of ticks by preloading bytes near all ones. Directed sequences hit each mode's carry, reload and split-flag routing at known literal values. A long random phase of mode writes, preloads, pin edges, gating and acknowledges is then compared each cycle against a behavioural model of the flags and the readable registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_PRESC  = 2'b00,
    TM_WIDE   = 2'b01,
    TM_RELOAD = 2'b10,
    TM_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } tmr_ctl_t;

  localparam int unsigned RA_MODE = 0;
  localparam int unsigned RA_LO0  = 1;
  localparam int unsigned RA_FLAG = 5;

endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int W      = 4,
  parameter int FALL_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      lvl_o,
  output logic [FALL_W-1:0] fall_o
);

  logic [W-1:0]      chain_q [STAGES];
  logic [FALL_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1][FALL_W-1:0];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1][FALL_W-1:0];

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode_i,
  input  logic              step_i,
  input  logic              hi_step_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              hi_ovf_o
);

  localparam int CAT_W = 2 * DATA_W;

  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [DATA_W-1:0] sp_lo_d, sp_hi_d;
  logic              sp_ovf, sp_hov;
  logic [PRE_W-1:0]  pre_nx;
  logic [CAT_W-1:0]  cat_nx;
  logic              upd_en;

  assign pre_nx = lo_q[PRE_W-1:0] + PRE_W'(1);
  assign cat_nx = {hi_q, lo_q} + CAT_W'(1);
  assign upd_en = step_i | hi_step_i | wr_lo_i | wr_hi_i;

  generate
    if (SPLIT_CAP) begin : g_split
      always_comb begin
        sp_lo_d = lo_q;
        sp_ovf  = 1'b0;
        sp_hi_d = hi_q;
        sp_hov  = 1'b0;
        if (step_i) begin
          sp_lo_d = lo_q + DATA_W'(1);
          sp_ovf  = &lo_q;
        end
        if (hi_step_i && mode_i == TM_SPLIT) begin
          sp_hi_d = hi_q + DATA_W'(1);
          sp_hov  = &hi_q;
        end
      end
    end else begin : g_stop
      assign sp_lo_d = lo_q;
      assign sp_hi_d = hi_q;
      assign sp_ovf  = 1'b0;
      assign sp_hov  = 1'b0;

      // R9
      stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_SPLIT && (step_i || hi_step_i) && !wr_lo_i && !wr_hi_i)
          |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ovf_o = 1'b0;
    case (mode_i)
      TM_PRESC: begin
        if (step_i) begin
          lo_d[PRE_W-1:0] = pre_nx;
          if (&lo_q[PRE_W-1:0]) begin
            hi_d  = hi_q + DATA_W'(1);
            ovf_o = &hi_q;
          end
        end
      end
      TM_WIDE: begin
        if (step_i) begin
          {hi_d, lo_d} = cat_nx;
          ovf_o        = &{hi_q, lo_q};
        end
      end
      TM_RELOAD: begin
        if (step_i) begin
          if (&lo_q) begin
            lo_d  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + DATA_W'(1);
          end
        end
      end
      default: begin
        lo_d  = sp_lo_d;
        hi_d  = sp_hi_d;
        ovf_o = sp_ovf;
      end
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (upd_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign hi_ovf_o = sp_hov;

  // R5
  presc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TM_PRESC && !wr_lo_i)
      |=> lo_q[DATA_W-1:PRE_W] == $past(lo_q[DATA_W-1:PRE_W]));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TM_RELOAD && step_i && (&lo_q) && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == $past(hi_q) && $stable(hi_q)));

endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        run_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic [1:0]        ack_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [1:0]        ovf_o
);

  localparam int NCH    = 2;
  localparam int CTL_W  = $bits(tmr_ctl_t);
  localparam int MODE_W = NCH * CTL_W;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(RA_MODE);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(RA_FLAG);

  logic rst_meta_q, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rst_meta_q} <= 2'b00;
    else        {rst_sn, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [NCH-1:0]    flag_q, flag_d, pend_q, pend_d;
  logic [NCH-1:0]    flag_set, flag_clr;
  logic [2*NCH-1:0]  pin_lvl;
  logic [NCH-1:0]    pin_fall;
  logic [NCH-1:0]    evt, run_ok, step, hi_step, wr_lo, wr_hi;
  logic [NCH-1:0]    ovf_main, hi_ovf;
  logic [DATA_W-1:0] lo_w [NCH];
  logic [DATA_W-1:0] hi_w [NCH];
  tmr_ctl_t          ctl  [NCH];
  logic              split0, wr_mode, wr_flag;

  tmr_insync #(
    .W      (2*NCH),
    .FALL_W (NCH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_sn),
    .pin_i  ({gate_pin_i, cnt_pin_i}),
    .lvl_o  (pin_lvl),
    .fall_o (pin_fall)
  );

  assign wr_mode = bus_wr_i && bus_addr_i == A_MODE;
  assign wr_flag = bus_wr_i && bus_addr_i == A_FLAG;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ctl[c]     = tmr_ctl_t'(mode_q[c*CTL_W +: CTL_W]);
      assign evt[c]     = pend_q[c] | pin_fall[c];
      assign run_ok[c]  = run_i[c] & (~ctl[c].gate | pin_lvl[NCH+c]);
      assign step[c]    = tick_i & run_ok[c] & (~ctl[c].ext | evt[c]);
      assign hi_step[c] = tick_i & run_i[NCH-1];
      assign pend_d[c]  = tick_i ? 1'b0 : evt[c];
      assign wr_lo[c]   = bus_wr_i && bus_addr_i == ADDR_W'(RA_LO0 + 2*c);
      assign wr_hi[c]   = bus_wr_i && bus_addr_i == ADDR_W'(RA_LO0 + 2*c + 1);
      assign flag_clr[c] = ack_i[c] | (wr_flag & ~bus_wdata_i[c]);

      tmr_chan #(
        .DATA_W    (DATA_W),
        .PRE_W     (PRE_W),
        .SPLIT_CAP (c == 0)
      ) u_chan (
        .clk       (clk),
        .rst_n     (rst_sn),
        .mode_i    (ctl[c].mode),
        .step_i    (step[c]),
        .hi_step_i (hi_step[c]),
        .wr_lo_i   (wr_lo[c]),
        .wr_hi_i   (wr_hi[c]),
        .wdata_i   (bus_wdata_i),
        .lo_o      (lo_w[c]),
        .hi_o      (hi_w[c]),
        .ovf_o     (ovf_main[c]),
        .hi_ovf_o  (hi_ovf[c])
      );
    end
  endgenerate

  assign split0      = ctl[0].mode == TM_SPLIT;
  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = (ovf_main[1] & ~split0) | (|hi_ovf);

  always_comb begin
    mode_d = wr_mode ? bus_wdata_i[MODE_W-1:0] : mode_q;
    flag_d = flag_set | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= '0;
      flag_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_MODE)                    bus_rdata_o = DATA_W'(mode_q);
    else if (bus_addr_i == A_FLAG)               bus_rdata_o = DATA_W'(flag_q);
    else if (bus_addr_i == ADDR_W'(RA_LO0))      bus_rdata_o = lo_w[0];
    else if (bus_addr_i == ADDR_W'(RA_LO0 + 1))  bus_rdata_o = hi_w[0];
    else if (bus_addr_i == ADDR_W'(RA_LO0 + 2))  bus_rdata_o = lo_w[1];
    else if (bus_addr_i == ADDR_W'(RA_LO0 + 3))  bus_rdata_o = hi_w[1];
  end

  assign ovf_o = flag_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ovf_main[0] |=> ovf_o[0]);

  // R11
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_i[0] && !ovf_main[0]) |=> !ovf_o[0]);

  // R8
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (split0 && !hi_ovf[0] && !ovf_o[1]) |=> !ovf_o[1]);

endmodule

// File: tb/sim_dual_tmr_unit.sv
module sim_dual_tmr_unit;
  localparam int SY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, bus_wr = 1'b0;
  logic [1:0] run = '0, cnt_pin = '0, gate_pin = '0, ack = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ovf;

  always #5 clk = ~clk;

  dual_tmr_unit #(.DATA_W(8), .PRE_W(5), .SYNC_STAGES(SY), .ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run), .cnt_pin_i(cnt_pin),
    .gate_pin_i(gate_pin), .ack_i(ack), .bus_wr_i(bus_wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ovf_o(ovf));

  int n_chk = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model
  int m_mode, m_lo[2], m_hi[2], m_flag[2], m_pend[2], m_prev[2];
  logic [3:0] m_sy [SY];

  function automatic int mread(int a);
    case (a)
      0: return m_mode;
      1: return m_lo[0];
      2: return m_hi[0];
      3: return m_lo[1];
      4: return m_hi[1];
      5: return m_flag[1] * 2 + m_flag[0];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    int md, gb, sl, mm, fall, evt, st, p, v, hov, nmode;
    int nlo[2], nhi[2], ov[2], np[2];
    bit sset, sclr;
    logic [3:0] last;
    if (!rst_n) begin
      m_mode = 0;
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; m_flag[c] = 0; m_pend[c] = 0; m_prev[c] = 0;
      end
      for (int k = 0; k < SY; k++) m_sy[k] = '0;
    end else begin
      last = m_sy[SY-1];
      for (int c = 0; c < 2; c++) begin
        md = (m_mode >> (4*c)) & 15;
        gb = (md >> 3) & 1; sl = (md >> 2) & 1; mm = md & 3;
        fall = (m_prev[c] == 1 && last[c] == 1'b0) ? 1 : 0;
        evt = (m_pend[c] == 1 || fall == 1) ? 1 : 0;
        st = (tick && run[c] && (gb == 0 || last[2+c]) && (sl == 0 || evt == 1)) ? 1 : 0;
        np[c] = tick ? 0 : evt;
        nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; ov[c] = 0;
        if (st == 1) begin
          case (mm)
            0: begin
              p = (m_lo[c] & 31) + 1;
              nlo[c] = (m_lo[c] & 224) | (p & 31);
              if (p == 32) begin
                nhi[c] = (m_hi[c] + 1) & 255;
                ov[c] = (m_hi[c] == 255) ? 1 : 0;
              end
            end
            1: begin
              v = m_hi[c] * 256 + m_lo[c] + 1;
              ov[c] = (v == 65536) ? 1 : 0;
              nlo[c] = v & 255; nhi[c] = (v >> 8) & 255;
            end
            2: begin
              if (m_lo[c] == 255) begin nlo[c] = m_hi[c]; ov[c] = 1; end
              else nlo[c] = m_lo[c] + 1;
            end
            default: if (c == 0) begin
              nlo[c] = (m_lo[c] + 1) & 255;
              ov[c] = (m_lo[c] == 255) ? 1 : 0;
            end
          endcase
        end
      end
      hov = 0;
      if ((m_mode & 3) == 3 && tick && run[1]) begin
        hov = (m_hi[0] == 255) ? 1 : 0;
        nhi[0] = (m_hi[0] + 1) & 255;
      end
      nmode = m_mode;
      if (bus_wr) begin
        case (addr)
          3'd0: nmode = wdata;
          3'd1: nlo[0] = wdata;
          3'd2: nhi[0] = wdata;
          3'd3: nlo[1] = wdata;
          3'd4: nhi[1] = wdata;
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        if (c == 0) sset = (ov[0] == 1);
        else        sset = (ov[1] == 1 && (m_mode & 3) != 3) || hov == 1;
        sclr = ack[c] || (bus_wr && addr == 3'd5 && wdata[c] == 1'b0);
        if (sset) m_flag[c] = 1;
        else if (sclr) m_flag[c] = 0;
        m_lo[c] = nlo[c]; m_hi[c] = nhi[c]; m_pend[c] = np[c];
        m_prev[c] = last[c] ? 1 : 0;
      end
      m_mode = nmode;
      for (int k = SY-1; k > 0; k--) m_sy[k] = m_sy[k-1];
      m_sy[0] = {gate_pin, cnt_pin};
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      #2;
      chk("R10 flags vs model", ovf, m_flag[1] * 2 + m_flag[0]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    addr = 3'(a);
    #1;
    chk(req, int'(rdata), exp);
    chk({req, " model"}, int'(rdata), mread(a));
  endtask

  task automatic fall_edge();
    cnt_pin[0] = 1'b1; cyc(4);
    cnt_pin[0] = 1'b0; cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    chk_on = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(a, 0, "R1 reset");

    // R6 16-bit cascade
    wr(0, 8'h01); wr(1, 8'hFE); wr(2, 8'hFF);
    run = 2'b01;
    ticks(2);
    rd(1, 0, "R6 low"); rd(2, 0, "R6 high"); rd(5, 1, "R10 flag0 set");

    // R11 write 0 clears, write 1 ignored
    wr(5, 8'h02);
    rd(5, 0, "R11 write clear");

    // R5 13-bit with prescaler, upper bits held
    wr(0, 8'h00); wr(1, 8'hFE); wr(2, 8'hFF);
    ticks(2);
    rd(1, 8'hE0, "R5 low upper held"); rd(2, 0, "R5 high"); rd(5, 1, "R5 ovf");
    wr(1, 8'h1F); wr(2, 8'h05);
    ticks(1);
    rd(1, 0, "R5 carry low"); rd(2, 6, "R5 carry high");

    // R7 auto-reload
    wr(0, 8'h02); wr(2, 8'hF0); wr(1, 8'hFF);
    ticks(1);
    rd(1, 8'hF0, "R7 reloaded"); rd(2, 8'hF0, "R7 high kept");
    ticks(1);
    rd(1, 8'hF1, "R7 after reload");
    ack = 2'b01; cyc(1); ack = 2'b00;
    rd(5, 0, "R11 ack clear");

    // R3 gating, R12 run does not clear
    wr(0, 8'h09); wr(1, 0); wr(2, 0);
    ticks(5);
    rd(1, 0, "R3 gate low blocks");
    gate_pin[0] = 1'b1; cyc(4);
    ticks(5);
    rd(1, 5, "R3 gate high counts");
    run = 2'b00; ticks(3);
    rd(1, 5, "R3 run off holds");
    run = 2'b01; ticks(2);
    rd(1, 7, "R12 resume from held");
    gate_pin[0] = 1'b0; cyc(4);

    // R4 external events
    wr(0, 8'h05); wr(1, 0); wr(2, 0);
    tick = 1'b1;
    fall_edge(); fall_edge(); fall_edge();
    cyc(4);
    tick = 1'b0;
    rd(1, 3, "R4 one per fall");
    fall_edge(); fall_edge();
    ticks(1);
    rd(1, 4, "R4 one per tick");

    // R8 split mode
    wr(0, 8'h13); wr(5, 0);
    wr(1, 8'hFE); wr(2, 8'hFE); wr(3, 0); wr(4, 0);
    rd(0, 8'h13, "R2 mode readback");
    run = 2'b11;
    ticks(2);
    rd(1, 0, "R8 low byte"); rd(2, 0, "R8 high byte"); rd(3, 2, "R8 ch1 counts");
    rd(5, 3, "R8 both flags");
    wr(5, 0); wr(3, 8'hFF); wr(4, 8'hFF);
    ticks(1);
    rd(3, 0, "R8 ch1 rolled"); rd(5, 0, "R8 ch1 flag untouched");

    // R9 channel 1 stopped
    wr(0, 8'h30); wr(3, 8'h12); wr(4, 8'h34);
    run = 2'b10;
    ticks(5);
    rd(3, 8'h12, "R9 low held"); rd(4, 8'h34, "R9 high held");

    // R12 write beats increment
    wr(0, 8'h01); wr(1, 8'h10); wr(2, 0);
    run = 2'b01;
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; addr = 3'd1; wdata = 8'h80;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(1, 8'h80, "R12 write priority");

    // R10 set beats clear
    wr(1, 8'hFF); wr(2, 8'hFF);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; addr = 3'd5; wdata = 8'h00;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(5, 1, "R10 set wins");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom % 3) != 0;
      ack = '0;
      bus_wr = 1'b0;
      if ($urandom % 40 == 0) run = 2'($urandom);
      if ($urandom % 3 == 0) cnt_pin = cnt_pin ^ 2'($urandom);
      if ($urandom % 20 == 0) gate_pin = 2'($urandom);
      if ($urandom % 30 == 0) ack = 2'($urandom);
      if ($urandom % 12 == 0) begin
        bus_wr = 1'b1;
        addr = 3'($urandom % 6);
        wdata = (($urandom % 4) == 0) ? 8'($urandom) : 8'hF0 | 8'($urandom % 16);
      end else if (i % 8 == 0) begin
        addr = 3'($urandom % 8);
        #1;
        chk("R2 random readback", int'(rdata), mread(int'(addr)));
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; ack = '0;
    cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule